// File: doc/BRIEF.md
# Per-Core Local Interrupt Register Window

This block keeps a small bank of local interrupt registers for every processor core in a cluster. Each bank has a read-only capability register, a pending register, a routing mask, and two map registers. One map register steers the core's timer event to an output pin. The other steers its performance-counter event.

All cores share one register port, and every access carries the number of the core that issues it. A core reaches its own bank through the local window. It reaches any other core's bank through the remote window. The remote window is aimed by a per-core selector register, which that core writes beforehand in its local window.

The block samples the per-core timer and counter event levels. It drives a registered, level-type pin request vector for each core: a pin is high while any enabled source mapped to it is active. Routing of each source can be turned off for a given core at build time. For such a core, that source's map register cannot be written.

Top module: `lirq_window`

## Requirements
- R1: Address bit 3 picks the window (0 local, 1 remote), and bits 2:0 give the word offset. Local offset 5 is the issuing core's 8-bit selector: it resets to 0 and reads back as written. Every later remote access by that core targets the bank of the core the selector names.
- R2: Offset 0 is read-only. It reads bit 0 = timer routable and bit 1 = counter routable for the target core, and a write to it has no effect.
- R3: Offset 1 is read-only. It reads bit 0 = timer event level and bit 1 = counter event level of the target core.
- R4: Offsets 3 (timer map) and 4 (counter map) hold a pin number in bits 2:0 and a map enable in bit 31. All other bits read 0, and both registers reset to 0.
- R5: A write to a map register whose source is not routable on the target core is dropped, that register always reads 0, and that source never drives a pin.
- R6: Offset 2 is the routing mask, bit 0 = timer and bit 1 = counter, and it resets to 0. A source drives its pin only while its mask bit is set.
- R7: Output `pin_req[c*6+p]` is high in the cycle after core c has an active source that is enabled, unmasked and mapped to pin p. It is the OR of both sources, and it drops one cycle after the sources go inactive. Pin numbers 6 and 7 drive nothing.
- R8: When the selector holds a value of 4 or more, remote reads return 0 and remote writes change no register.
- R9: Local offset 6 is read-only and returns the core count minus one (3).
- R10: Read data appears on `bus_rdata` in the cycle after the read and is 0 in every other cycle. Local offset 7, and remote offsets 5 to 7, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_core | input | 2 | Number of the core issuing the access |
| bus_addr | input | 4 | Window bit and word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| timer_evt | input | 4 | Timer event level per core |
| perf_evt | input | 4 | Performance-counter event level per core |
| pin_req | output | 24 | Pin request per core, 6 pins each |

## Verification
The hardest case to reach is one core writing another core's registers through the remote window. The effect of such a write is visible only when a different core reads its own local window, or at that core's pins. The stimulus first makes core 0 aim its selector at core 1 and writes core 1's map and mask registers remotely. It then reads them back as core 1 and raises core 1's events to see which pin moves. The same route, with the selector set out of range and with a source that cannot be routed, shows that dropped writes leave every bank untouched.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int DATA_W     = 32;
  localparam int OFF_W      = 3;
  localparam int SEL_W      = 8;
  localparam int MAP_EN_BIT = 31;

  typedef enum logic [OFF_W-1:0] {
    OFF_CTRL = 3'd0,
    OFF_PEND = 3'd1,
    OFF_MASK = 3'd2,
    OFF_TMAP = 3'd3,
    OFF_PMAP = 3'd4,
    OFF_SEL  = 3'd5,
    OFF_CFG  = 3'd6,
    OFF_NONE = 3'd7
  } lirq_off_e;
endpackage

// File: rtl/lirq_rst_sync.sv
module lirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/lirq_decode.sv
module lirq_decode
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [CORE_W-1:0] bus_core,
  input  logic [OFF_W:0]    bus_addr,
  input  logic [SEL_W-1:0]  sel_req,
  output logic              is_other,
  output lirq_off_e         off,
  output logic [CORE_W-1:0] tgt_core,
  output logic              tgt_ok,
  output logic              acc_rd,
  output logic              acc_wr
);
  always_comb begin
    is_other = bus_addr[OFF_W];
    off      = lirq_off_e'(bus_addr[OFF_W-1:0]);
    acc_rd   = bus_valid && !bus_write;
    acc_wr   = bus_valid && bus_write;
    if (is_other) begin
      tgt_core = sel_req[CORE_W-1:0];
      tgt_ok   = (int'(sel_req) < NUM_CORES);
    end else begin
      tgt_core = bus_core;
      tgt_ok   = (int'(bus_core) < NUM_CORES);
    end
  end
endmodule

// File: rtl/lirq_core_regs.sv
module lirq_core_regs
  import lirq_pkg::*;
#(
  parameter int   PIN_IDX_W   = 3,
  parameter logic TIMER_RTBL  = 1'b1,
  parameter logic PERF_RTBL   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  lirq_off_e            off,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 timer_evt,
  input  logic                 perf_evt,
  output logic [DATA_W-1:0]    rd_data,
  output logic [1:0]           mask,
  output logic                 tmap_en,
  output logic [PIN_IDX_W-1:0] tmap_pin,
  output logic                 pmap_en,
  output logic [PIN_IDX_W-1:0] pmap_pin
);
  logic [1:0]           mask_q, mask_d;
  logic                 ten_q, ten_d, pen_q, pen_d;
  logic [PIN_IDX_W-1:0] tpin_q, tpin_d, ppin_q, ppin_d;
  logic                 t_wr, p_wr;
  logic                 unused_wbits;

  assign unused_wbits = ^wdata;

  // map writes are gated by the build-time routability of each source
  assign t_wr = wr_en && (off == OFF_TMAP) && TIMER_RTBL;
  assign p_wr = wr_en && (off == OFF_PMAP) && PERF_RTBL;

  always_comb begin
    mask_d = mask_q;
    ten_d  = ten_q;
    tpin_d = tpin_q;
    pen_d  = pen_q;
    ppin_d = ppin_q;
    if (wr_en && (off == OFF_MASK)) mask_d = wdata[1:0];
    if (t_wr) begin
      ten_d  = wdata[MAP_EN_BIT];
      tpin_d = wdata[PIN_IDX_W-1:0];
    end
    if (p_wr) begin
      pen_d  = wdata[MAP_EN_BIT];
      ppin_d = wdata[PIN_IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ten_q  <= 1'b0;
      tpin_q <= '0;
      pen_q  <= 1'b0;
      ppin_q <= '0;
    end else begin
      mask_q <= mask_d;
      ten_q  <= ten_d;
      tpin_q <= tpin_d;
      pen_q  <= pen_d;
      ppin_q <= ppin_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (off)
      OFF_CTRL: rd_data[1:0] = {PERF_RTBL, TIMER_RTBL};
      OFF_PEND: rd_data[1:0] = {perf_evt, timer_evt};
      OFF_MASK: rd_data[1:0] = mask_q;
      OFF_TMAP: begin
        rd_data[MAP_EN_BIT]    = ten_q;
        rd_data[PIN_IDX_W-1:0] = tpin_q;
      end
      OFF_PMAP: begin
        rd_data[MAP_EN_BIT]    = pen_q;
        rd_data[PIN_IDX_W-1:0] = ppin_q;
      end
      default: rd_data = '0;
    endcase
  end

  assign mask     = mask_q;
  assign tmap_en  = ten_q;
  assign tmap_pin = tpin_q;
  assign pmap_en  = pen_q;
  assign pmap_pin = ppin_q;

  assert_tmap_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_TMAP && !TIMER_RTBL) |=> ($stable(ten_q) && $stable(tpin_q)));
  assert_pmap_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_PMAP && !PERF_RTBL) |=> ($stable(pen_q) && $stable(ppin_q)));
  assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_MASK) |=> (mask_q == $past(wdata[1:0])));
endmodule

// File: rtl/lirq_pin_route.sv
module lirq_pin_route #(
  parameter int NUM_PINS  = 6,
  parameter int PIN_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 timer_evt,
  input  logic                 perf_evt,
  input  logic [1:0]           mask,
  input  logic                 tmap_en,
  input  logic [PIN_IDX_W-1:0] tmap_pin,
  input  logic                 pmap_en,
  input  logic [PIN_IDX_W-1:0] pmap_pin,
  output logic [NUM_PINS-1:0]  pin_q
);
  logic                t_act, p_act;
  logic [NUM_PINS-1:0] pin_d;

  assign t_act = timer_evt && tmap_en && mask[0];
  assign p_act = perf_evt  && pmap_en && mask[1];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_d[p] = (t_act && (tmap_pin == PIN_IDX_W'(p))) ||
                      (p_act && (pmap_pin == PIN_IDX_W'(p)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  assert_pin_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(timer_evt || perf_evt) |=> (pin_q == '0));
  assert_pin_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q != '0) |-> $past(timer_evt || perf_evt));
  assert_pin_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |=> (pin_q == '0));
endmodule

// File: rtl/lirq_window.sv
module lirq_window
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 6,
  parameter logic [NUM_CORES-1:0] TIMER_ROUTABLE = 4'b1101,
  parameter logic [NUM_CORES-1:0] PERF_ROUTABLE  = 4'b1011,
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W    = OFF_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [CORE_W-1:0]             bus_core,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_CORES-1:0]          timer_evt,
  input  logic [NUM_CORES-1:0]          perf_evt,
  output logic [NUM_CORES*NUM_PINS-1:0] pin_req
);
  logic              rst_s_n;
  logic [SEL_W-1:0]  sel_q [NUM_CORES];
  logic [SEL_W-1:0]  sel_req;
  logic              core_ok;
  logic              is_other, tgt_ok, acc_rd, acc_wr, sel_wr;
  lirq_off_e         off;
  logic [CORE_W-1:0] tgt_core;
  logic [DATA_W-1:0] core_rd [NUM_CORES];
  logic [DATA_W-1:0] rd_mux, rdata_d, rdata_q;

  lirq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n));

  assign core_ok = (int'(bus_core) < NUM_CORES);
  assign sel_req = core_ok ? sel_q[bus_core] : '0;

  lirq_decode #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_core(bus_core),
    .bus_addr(bus_addr), .sel_req(sel_req), .is_other(is_other), .off(off),
    .tgt_core(tgt_core), .tgt_ok(tgt_ok), .acc_rd(acc_rd), .acc_wr(acc_wr)
  );

  assign sel_wr = acc_wr && !is_other && (off == OFF_SEL) && core_ok;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [SEL_W-1:0]     sel_d;
    logic                 wr_en;
    logic [1:0]           mask;
    logic                 ten, pen;
    logic [PIN_IDX_W-1:0] tpin, ppin;

    assign sel_d = (sel_wr && (bus_core == CORE_W'(c))) ? bus_wdata[SEL_W-1:0] : sel_q[c];

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) sel_q[c] <= '0;
      else          sel_q[c] <= sel_d;
    end

    assign wr_en = acc_wr && tgt_ok && (tgt_core == CORE_W'(c)) &&
                   (off != OFF_SEL) && (off != OFF_CFG);

    lirq_core_regs #(
      .PIN_IDX_W(PIN_IDX_W),
      .TIMER_RTBL(TIMER_ROUTABLE[c]),
      .PERF_RTBL(PERF_ROUTABLE[c])
    ) u_regs (
      .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .off(off), .wdata(bus_wdata),
      .timer_evt(timer_evt[c]), .perf_evt(perf_evt[c]), .rd_data(core_rd[c]),
      .mask(mask), .tmap_en(ten), .tmap_pin(tpin), .pmap_en(pen), .pmap_pin(ppin)
    );

    lirq_pin_route #(.NUM_PINS(NUM_PINS), .PIN_IDX_W(PIN_IDX_W)) u_route (
      .clk(clk), .rst_n(rst_s_n), .timer_evt(timer_evt[c]), .perf_evt(perf_evt[c]),
      .mask(mask), .tmap_en(ten), .tmap_pin(tpin), .pmap_en(pen), .pmap_pin(ppin),
      .pin_q(pin_req[c*NUM_PINS +: NUM_PINS])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (!is_other && (off == OFF_SEL)) begin
      rd_mux[SEL_W-1:0] = sel_req;
    end else if (!is_other && (off == OFF_CFG)) begin
      rd_mux = DATA_W'(NUM_CORES - 1);
    end else if (tgt_ok) begin
      rd_mux = core_rd[tgt_core];
    end
  end

  assign rdata_d = acc_rd ? rd_mux : '0;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(bus_valid && !bus_write) |=> (bus_rdata == '0));
  assert_oob_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_valid && !bus_write && bus_addr[OFF_W] && (int'(sel_req) >= NUM_CORES))
      |=> (bus_rdata == '0));
  assert_cfg_read_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_valid && !bus_write && !bus_addr[OFF_W] && bus_addr[OFF_W-1:0] == 3'd6)
      |=> (bus_rdata == DATA_W'(NUM_CORES - 1)));
  assert_sel_update_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_valid && bus_write && !bus_addr[OFF_W] && bus_addr[OFF_W-1:0] == 3'd5 && core_ok)
      |=> (sel_q[$past(bus_core)] == $past(bus_wdata[SEL_W-1:0])));
endmodule

// File: tb/lirq_window_bench.sv
`timescale 1ns/100ps
module lirq_window_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [1:0]  bus_core;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  timer_evt, perf_evt;
  logic [23:0] pin_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic rd_flag = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  lirq_window u_lirq_window (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .timer_evt(timer_evt), .perf_evt(perf_evt),
    .pin_req(pin_req)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: a read issued before the last edge is compared now
  always @(posedge clk) rd_flag <= bus_valid && !bus_write;
  always @(negedge clk) begin
    if (rd_flag && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(bus_rdata, e, t);
    end
  end

  task automatic wr(input logic [1:0] c, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_core = c; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] c, input logic [3:0] a, input logic [31:0] e,
                    input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_core = c; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic evt(input logic [3:0] t, input logic [3:0] p, input logic [23:0] e,
                     input string tag);
    @(negedge clk);
    timer_evt = t; perf_evt = p;
    @(negedge clk);
    chk({8'h0, pin_req}, {8'h0, e}, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_core = '0;
    bus_addr = '0; bus_wdata = '0; timer_evt = '0; perf_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(bus_rdata, 32'h0, "R10 reset rdata");
    chk({8'h0, pin_req}, 32'h0, "R7 reset pins");
    rd(0, 4'h5, 32'h0, "R1 selector reset");
    rd(0, 4'h3, 32'h0, "R4 map reset");

    rd(0, 4'h6, 32'h3, "R9 core count");
    wr(0, 4'h6, 32'h0);
    chk(bus_rdata, 32'h0, "R10 rdata after write");
    rd(0, 4'h6, 32'h3, "R9 read only");

    rd(0, 4'h0, 32'h3, "R2 ctrl core0");
    rd(1, 4'h0, 32'h2, "R2 ctrl core1");
    rd(2, 4'h0, 32'h1, "R2 ctrl core2");
    rd(3, 4'h0, 32'h3, "R2 ctrl core3");
    wr(0, 4'h0, 32'h0);
    rd(0, 4'h0, 32'h3, "R2 ctrl read only");

    wr(0, 4'h3, 32'hFFFF_FFFF);
    rd(0, 4'h3, 32'h8000_0007, "R4 map field bits");
    wr(0, 4'h3, 32'h8000_0002);
    rd(0, 4'h3, 32'h8000_0002, "R4 map readback");

    evt(4'h1, 4'h0, 24'h0, "R6 mask clear blocks");
    evt(4'h0, 4'h0, 24'h0, "R7 idle");
    wr(0, 4'h2, 32'h3);
    rd(0, 4'h2, 32'h3, "R6 mask readback");

    evt(4'h1, 4'h0, 24'h4, "R7 timer to pin2");
    wr(0, 4'h4, 32'h8000_0002);
    evt(4'h1, 4'h1, 24'h4, "R7 both on pin2");
    evt(4'h0, 4'h1, 24'h4, "R7 counter alone pin2");
    rd(0, 4'h1, 32'h2, "R3 pending counter only");
    evt(4'h1, 4'h0, 24'h4, "R7 timer alone");
    rd(0, 4'h1, 32'h1, "R3 pending timer only");
    evt(4'h0, 4'h0, 24'h0, "R7 drops next cycle");

    wr(0, 4'h5, 32'h1);
    rd(0, 4'h5, 32'h1, "R1 selector readback");
    rd(0, 4'h8, 32'h2, "R1 remote ctrl of core1");
    wr(0, 4'hB, 32'h8000_0001);
    rd(1, 4'h3, 32'h0, "R5 timer map locked");
    rd(0, 4'hB, 32'h0, "R5 locked reads zero remote");
    wr(0, 4'hC, 32'h8000_0005);
    rd(1, 4'h4, 32'h8000_0005, "R1 remote map write landed");
    wr(0, 4'hA, 32'h3);
    rd(1, 4'h2, 32'h3, "R1 remote mask write landed");
    rd(0, 4'h2, 32'h3, "R1 own mask untouched");
    evt(4'h2, 4'h0, 24'h0, "R5 locked timer drives nothing");
    evt(4'h0, 4'h2, 24'h80_0, "R7 core1 counter pin5");
    rd(0, 4'h9, 32'h2, "R3 remote pending");
    evt(4'h0, 4'h0, 24'h0, "R7 core1 drop");

    wr(0, 4'h5, 32'h7);
    rd(0, 4'h5, 32'h7, "R1 selector out of range");
    rd(0, 4'h8, 32'h0, "R8 remote ctrl zero");
    rd(0, 4'hA, 32'h0, "R8 remote mask zero");
    wr(0, 4'hA, 32'h0);
    rd(1, 4'h2, 32'h3, "R8 core1 mask untouched");
    rd(3, 4'h2, 32'h0, "R8 core3 mask untouched");
    rd(0, 4'h2, 32'h3, "R8 core0 mask untouched");

    wr(3, 4'h3, 32'h8000_0007);
    wr(3, 4'h2, 32'h1);
    rd(3, 4'h3, 32'h8000_0007, "R4 core3 map");
    evt(4'h8, 4'h0, 24'h0, "R7 pin7 drives nothing");
    evt(4'h0, 4'h0, 24'h0, "R7 idle again");

    rd(3, 4'hE, 32'h0, "R10 remote cfg zero");
    rd(3, 4'hD, 32'h0, "R10 remote selector zero");
    rd(3, 4'h7, 32'h0, "R10 unused offset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule